// File: doc/BRIEF.md
# Sequential Booth Multiplier (Low Product Word)

This block multiplies two 32-bit operands over several clock cycles using radix-2 Booth recoding. A one-cycle start pulse captures both operands. A small state machine then makes exactly one pass per cycle over the multiplier bits. On each pass it looks at the current low bit of the multiplier register together with the bit shifted out on the previous pass. It adds the multiplicand, subtracts it, or leaves the accumulator alone, and then shifts the combined accumulator/multiplier register right by one position.

Only the low 32 bits of the product are delivered. These bits are the same whether the operands are read as signed or as unsigned numbers, so one datapath serves both kinds of multiply with no mode input. A registered Ready output marks completion. Ready and the product stay unchanged until the host starts the next operation.

Top module: `booth_mult`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, `ready_o` goes low and `product_o` goes to zero after that edge.
- R2: On completion, `product_o` equals (A × B) mod 2^32, where A and B are the values on `a_i` and `b_i` at the accepting edge. The value is the same for signed and unsigned readings of A and B.
- R3: `en_i` high at an edge where no multiplication is in progress is accepted. It captures `a_i` as multiplicand and `b_i` as multiplier, and `ready_o` goes low after that edge.
- R4: `ready_o` goes high after the 32nd rising edge that follows the accepting edge, and not earlier.
- R5: While `ready_o` is high and `en_i` stays low, `ready_o` and `product_o` hold their values, whatever `a_i` and `b_i` do.
- R6: `en_i` high while a multiplication is in progress has no effect. The running operation keeps its operands, its latency and its result.
- R7: `en_i` high while `ready_o` is high starts a new multiplication. `product_o` keeps the previous result until the new one completes.
- R8: Each pass applies Booth recoding to {multiplier LSB, previous bit}: 01 adds the multiplicand, 10 subtracts it, 00 and 11 leave the accumulator unchanged. The products of long runs of ones and of alternating bit patterns therefore still come out right.
- R9: A reset in the middle of a multiplication aborts it. No Ready pulse follows unless a new Enable arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Start pulse, sampled on the rising edge |
| a_i | input | 32 | Multiplicand operand |
| b_i | input | 32 | Multiplier operand |
| ready_o | output | 1 | High once the product is valid |
| product_o | output | 32 | Low 32 bits of the product |

## Verification
The assertions assume that `en_i` is a clean, synchronous level that is only meaningful at rising edges. They also assume that reset is held for at least one edge before any operation. The bench drives every input at the falling edge and keeps Enable high for exactly one edge per intended start, except where it deliberately holds Enable high during a busy period to probe R6. The cycle-count property relies on the busy interval being entered only through an accepted Enable, and every start in the stimulus comes from idle or from the completed state.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } state_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } op_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic q_lsb_i,
  input  logic q_prev_i,
  output op_t  op_o
);

  always_comb begin
    unique case ({q_lsb_i, q_prev_i})
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_NONE;
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic ready_o
);

  localparam int CNT_W = $clog2(WIDTH) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  state_t           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;

  assign busy_o  = (state_q == ST_RUN);
  assign load_o  = en_i && !busy_o;
  assign step_o  = busy_o;
  assign last_o  = busy_o && (cnt_q == LAST_CNT);
  assign ready_o = ready_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (step_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) begin
        state_q <= ST_DONE;
        ready_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o
);

  logic [WIDTH-1:0] mcand_q, acc_q, mq_q, result_q;
  logic             prev_q;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] acc_n, mq_n;
  op_t              op;

  booth_recoder rec_i (
    .q_lsb_i  (mq_q[0]),
    .q_prev_i (prev_q),
    .op_o     (op)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc_q + mcand_q;
      OP_SUB:  sum = acc_q - mcand_q;
      default: sum = acc_q;
    endcase
    acc_n = {sum[WIDTH-1], sum[WIDTH-1:1]};
    mq_n  = {sum[0], mq_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      mq_q     <= '0;
      prev_q   <= 1'b0;
      result_q <= '0;
    end else if (load_i) begin
      mcand_q <= a_i;
      acc_q   <= '0;
      mq_q    <= b_i;
      prev_q  <= 1'b0;
    end else if (step_i) begin
      acc_q  <= acc_n;
      mq_q   <= mq_n;
      prev_q <= mq_q[0];
      if (last_i) result_q <= mq_n;
    end
  end

  assign result_o = result_q;

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             ready_o,
  output logic [WIDTH-1:0] product_o
);

  logic load, step, last, busy;

  booth_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy),
    .ready_o (ready_o)
  );

  booth_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load),
    .step_i   (step),
    .last_i   (last),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (product_o)
  );

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             busy,
  input logic             ready_o,
  input logic [WIDTH-1:0] product_o
);

  localparam int CW = $clog2(WIDTH) + 2;

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !busy) cyc_q <= '0;
    else                cyc_q <= cyc_q + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!ready_o && product_o == '0));

  assert_restart_drops_ready_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && ready_o) |=> !ready_o);

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ready_o) |-> (cyc_q == CW'(WIDTH)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ready_o && !en_i) |=> (ready_o && $stable(product_o)));

  assert_busy_ignores_en_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && en_i && cyc_q < CW'(WIDTH - 1)) |=> busy);

  assert_product_held_while_busy_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && $past(busy)) |-> $stable(product_o) || $rose(ready_o));

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({busy, ready_o}));

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .en_i      (en_i),
  .busy      (busy),
  .ready_o   (ready_o),
  .product_o (product_o)
);

// File: tb/booth_mult_tb_top.sv
module booth_mult_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         ready;
  logic [W-1:0] product;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  booth_mult #(.WIDTH(W)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .en_i      (en),
    .a_i       (a),
    .b_i       (b),
    .ready_o   (ready),
    .product_o (product)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] full;
    full = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    return full[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive one start pulse; returns after the accepting edge, at a falling edge.
  task automatic start(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_mul(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    int n;
    start(x, y);
    chk(!ready, "R3 ready low after accept", W'(ready), '0);
    wait_ready(n);
    chk(n == W, "R4 latency", W'(n), W'(W));
    chk(product == ref_mul(x, y), req, product, ref_mul(x, y));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!ready, "R1 ready after reset", W'(ready), '0);
    chk(product == '0, "R1 product after reset", product, '0);
  endtask

  task automatic t_corners();
    logic [W-1:0] v [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};
    foreach (v[i]) foreach (v[j]) do_mul(v[i], v[j], "R2 corner product");
  endtask

  task automatic t_patterns();
    do_mul(32'h5555_5555, 32'hAAAA_AAAA, "R8 alternating bits");
    do_mul(32'h1234_5678, 32'h5555_5555, "R8 alternating multiplier");
    do_mul(32'hDEAD_BEEF, 32'h00FF_FF00, "R8 run of ones");
    do_mul(32'hFFFF_FFF9, 32'h0000_0007, "R2 signed -7*7");
    do_mul(32'hFFFF_FFFD, 32'hFFFF_FFFB, "R2 signed -3*-5");
  endtask

  task automatic t_random();
    for (int k = 0; k < 40; k++) do_mul($urandom, $urandom, "R2 random product");
  endtask

  task automatic t_hold();
    logic [W-1:0] keep;
    do_mul(32'h0000_1234, 32'h0000_0100, "R2 product before hold");
    keep = product;
    for (int k = 0; k < 10; k++) begin
      a = $urandom; b = $urandom;
      @(negedge clk);
    end
    chk(ready, "R5 ready held", W'(ready), 32'h1);
    chk(product == keep, "R5 product held", product, keep);
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [W-1:0] exp;
    exp = ref_mul(32'h0001_0003, 32'h0000_0011);
    start(32'h0001_0003, 32'h0000_0011);
    n = 0;
    for (int k = 0; k < 5; k++) begin @(negedge clk); n++; end
    a = 32'hFFFF_0000; b = 32'h0000_7777; en = 1'b1;
    @(negedge clk); n++;
    en = 1'b0;
    while (!ready && n < 100) begin @(negedge clk); n++; end
    chk(n == W, "R6 latency unchanged", W'(n), W'(W));
    chk(product == exp, "R6 result unchanged", product, exp);
  endtask

  task automatic t_restart();
    logic [W-1:0] prev;
    int n;
    do_mul(32'h0000_0009, 32'h0000_0009, "R2 product before restart");
    prev = product;
    start(32'h0000_0100, 32'h0000_0100);
    chk(!ready, "R7 ready drops on restart", W'(ready), '0);
    chk(product == prev, "R7 old product kept", product, prev);
    wait_ready(n);
    chk(product == 32'h0001_0000, "R7 new product", product, 32'h0001_0000);
  endtask

  task automatic t_abort();
    start(32'h0000_0055, 32'h0000_0033);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!ready && product == '0, "R9 cleared by reset", product, '0);
    repeat (40) @(negedge clk);
    chk(!ready, "R9 no ready after abort", W'(ready), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_corners();
    t_patterns();
    t_random();
    t_hold();
    t_busy_ignore();
    t_restart();
    t_abort();
    do_mul(32'h0000_0003, 32'h0000_0005, "R2 product after abort");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule